// File: doc/BRIEF.md
# Serial Peripheral Master Controller

This block is the single controller on a four-wire synchronous serial bus. A host loads a clock mode (idle polarity and sampling phase), the index of the target device, a frame length and the word to transmit, then pulses `start`. The block lowers that target's select line, runs the serial clock for the whole frame, drives the outgoing data line and samples the incoming one. When the frame is over it raises the select line, presents the received word and pulses `done` for one cycle.

The serial clock rate is the system clock divided by `2*(div+1)`. The frame is a continuous stream of bits with no framing bits around it. Outgoing data leaves most significant bit first. Incoming data is assembled least significant bit first. In normal mode the frame length comes from `nbits`. In chained mode all devices of a chain share one select, and the frame length is eight bits per chained device.

Top module: `spi_ctl`

## Requirements
- R1: During a frame each half-period of `sclk` lasts exactly `div+1` system clocks. A frame of L bits makes exactly 2*L `sclk` edges, one bit per `sclk` cycle.
- R2: While idle, `sclk` rests at the level of `cpol` (0 = low, 1 = high). This level is reached within two cycles of a change to `cpol`.
- R3: With `cpha`=0 the incoming bit is sampled on the first edge of each bit and `mosi` changes only on the second. With `cpha`=1 `mosi` changes on the first edge and the incoming bit is sampled on the second. `mosi` never changes on a sampling edge.
- R4: All `cs_n` lines are high while idle. The selected line falls at least `div+1` clocks before the first `sclk` edge and rises at least `div+1` clocks after the last one.
- R5: At most one `cs_n` line is ever low, and only the line with index `sel` latched at start.
- R6: `mosi` carries `tx_data[L-1]` first and `tx_data[0]` last. It is 0 while idle.
- R7: The first bit received lands in `rx_data[0]` and the last in `rx_data[L-1]`. Bits of `rx_data` at L and above read 0.
- R8: With `chain_en`=0 the frame length L equals `nbits` (1 to MAXBITS).
- R9: With `chain_en`=1 the frame length L is 8*`chain_len` and `nbits` is ignored.
- R10: `busy` is high from the cycle after an accepted start until `cs_n` rises. `done` is high for exactly that one cycle, with `busy` low. A start request made while `busy` is high is ignored.

Port names below refer to the default parameters: NSEL=4, MAXBITS=32, DIVW=8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request a frame; ignored while busy |
| cpol | input | 1 | Serial clock idle level |
| cpha | input | 1 | 0: sample on first edge; 1: sample on second edge |
| chain_en | input | 1 | Chained frame length selection |
| sel | input | $clog2(NSEL) | Index of the target select line |
| nbits | input | $clog2(MAXBITS)+1 | Frame length in normal mode |
| chain_len | input | $clog2(MAXBITS/8)+1 | Number of chained 8-bit devices |
| div | input | DIVW | Clock divider value |
| tx_data | input | MAXBITS | Word to transmit, right-aligned |
| miso | input | 1 | Serial data from the devices |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the devices |
| cs_n | output | NSEL | Active-low select lines |
| rx_data | output | MAXBITS | Received word, right-aligned |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle end-of-frame pulse |

## Verification
A wrong edge counter shows up at the ports as a frame that is too short or too long: the count of `sclk` edges between the fall and the rise of the select line is off, and the error is visible as soon as that select line rises. A wrong phase or index state inside the shifter shows up as a corrupted or bit-reversed word, either at the serial device model or in `rx_data`, in the cycle `done` pulses. A wrong divider or sequencer state shows up as a half-period of the wrong length, which is caught at the very next `sclk` edge.

// File: rtl/spi_ctl_pkg.sv
// Shared types for the serial master controller.
// Assumes: nothing beyond a standard SystemVerilog compile.
package spi_ctl_pkg;
    // Frame sequencer phases: idle, select lead-in, clocking, select lag.
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LEAD  = 2'd1,
        ST_XFER  = 2'd2,
        ST_TRAIL = 2'd3
    } spi_state_e;
endpackage

// File: rtl/spi_ctl_div.sv
// Half-period timebase: emits one tick every div+1 system clocks.
// Assumes: restart aligns the count at the beginning of each frame.
module spi_ctl_div #(
    parameter int DIVW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            restart,
    input  logic [DIVW-1:0] div,
    output logic            tick
);
    logic [DIVW-1:0] cnt_q;

    // Count down from div and reload after reaching zero or on restart.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (restart || cnt_q == '0) begin
            cnt_q <= div;
        end else begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // A tick marks the end of one half-period.
    always_comb tick = (cnt_q == '0) && !restart;
endmodule

// File: rtl/spi_ctl_shift.sv
// Data path: sends the transmit word high bit first, and collects
// the received bits low bit first into a right-aligned word.
// Assumes: len is between 1 and MAXBITS when load is asserted.
module spi_ctl_shift #(
    parameter int MAXBITS = 32,
    localparam int IDXW = $clog2(MAXBITS),
    localparam int LENW = $clog2(MAXBITS) + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [LENW-1:0]    len,
    input  logic [MAXBITS-1:0] tx_data,
    input  logic               adv,
    input  logic               smp,
    input  logic               miso,
    output logic               mosi_bit,
    output logic [MAXBITS-1:0] rx_data
);
    logic [MAXBITS-1:0] tx_q;
    logic [IDXW-1:0]    oidx_q;
    logic [IDXW-1:0]    ridx_q;

    // Capture the transmit word and walk the output index down.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_q   <= '0;
            oidx_q <= '0;
        end else if (load) begin
            tx_q   <= tx_data;
            oidx_q <= IDXW'(len - LENW'(1));
        end else if (adv && oidx_q != '0) begin
            oidx_q <= oidx_q - 1'b1;
        end
    end

    // Place each sampled bit at the next higher position.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_data <= '0;
            ridx_q  <= '0;
        end else if (load) begin
            rx_data <= '0;
            ridx_q  <= '0;
        end else if (smp) begin
            rx_data[ridx_q] <= miso;
            ridx_q          <= ridx_q + 1'b1;
        end
    end

    // The current output bit is selected by the index.
    always_comb mosi_bit = tx_q[oidx_q];
endmodule

// File: rtl/spi_ctl.sv
// Serial bus master top: frame sequencer, select decode and clock output.
// Assumes: all inputs except start and miso are held stable during a frame,
// and a chained length never exceeds MAXBITS.
module spi_ctl #(
    parameter int NSEL    = 4,
    parameter int MAXBITS = 32,
    parameter int DIVW    = 8,
    localparam int SELW = $clog2(NSEL),
    localparam int LENW = $clog2(MAXBITS) + 1,
    localparam int CHW  = $clog2(MAXBITS / 8) + 1,
    localparam int EW   = $clog2(2 * MAXBITS) + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic               cpol,
    input  logic               cpha,
    input  logic               chain_en,
    input  logic [SELW-1:0]    sel,
    input  logic [LENW-1:0]    nbits,
    input  logic [CHW-1:0]     chain_len,
    input  logic [DIVW-1:0]    div,
    input  logic [MAXBITS-1:0] tx_data,
    input  logic               miso,
    output logic               sclk,
    output logic               mosi,
    output logic [NSEL-1:0]    cs_n,
    output logic [MAXBITS-1:0] rx_data,
    output logic               busy,
    output logic               done
);
    import spi_ctl_pkg::*;

    spi_state_e     state_q;
    logic           cpha_q;
    logic           sclk_q;
    logic           done_q;
    logic [SELW-1:0] sel_q;
    logic [LENW-1:0] len_q;
    logic [EW-1:0]   edge_q;
    logic            tick;
    logic            take;
    logic            lead_edge;
    logic            clk_edge;
    logic            smp;
    logic            adv;
    logic            mosi_bit;
    logic [LENW-1:0] len_d;
    logic [EW-1:0]   last_edge;

    // Decide acceptance, frame length and the role of the coming edge.
    always_comb begin
        take      = (state_q == ST_IDLE) && start;
        len_d     = chain_en ? LENW'({chain_len, 3'b000}) : nbits;
        last_edge = EW'({len_q, 1'b0}) - EW'(1);
        lead_edge = ~edge_q[0];
        clk_edge  = tick && (state_q == ST_XFER);
        smp       = clk_edge && (lead_edge ^ cpha_q);
        adv       = clk_edge && (cpha_q ? (lead_edge && edge_q != '0) : !lead_edge);
    end

    spi_ctl_div #(.DIVW(DIVW)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (take),
        .div     (div),
        .tick    (tick)
    );

    spi_ctl_shift #(.MAXBITS(MAXBITS)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (take),
        .len      (len_d),
        .tx_data  (tx_data),
        .adv      (adv),
        .smp      (smp),
        .miso     (miso),
        .mosi_bit (mosi_bit),
        .rx_data  (rx_data)
    );

    // Frame sequencer: lead-in, edge generation, lag, then completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cpha_q  <= 1'b0;
            sclk_q  <= 1'b0;
            done_q  <= 1'b0;
            sel_q   <= '0;
            len_q   <= '0;
            edge_q  <= '0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    sclk_q <= cpol;
                    if (start) begin
                        cpha_q  <= cpha;
                        sel_q   <= sel;
                        len_q   <= len_d;
                        edge_q  <= '0;
                        state_q <= ST_LEAD;
                    end
                end
                ST_LEAD: if (tick) state_q <= ST_XFER;
                ST_XFER: begin
                    if (tick) begin
                        sclk_q <= ~sclk_q;
                        edge_q <= edge_q + 1'b1;
                        if (edge_q == last_edge) state_q <= ST_TRAIL;
                    end
                end
                default: begin
                    if (tick) begin
                        state_q <= ST_IDLE;
                        done_q  <= 1'b1;
                    end
                end
            endcase
        end
    end

    // One active-low select per target, decoded from the latched index.
    for (genvar g = 0; g < NSEL; g++) begin : g_sel
        assign cs_n[g] = !((state_q != ST_IDLE) && (sel_q == SELW'(g)));
    end

    // Drive the remaining outputs from sequencer state.
    always_comb begin
        busy = (state_q != ST_IDLE);
        sclk = sclk_q;
        mosi = busy ? mosi_bit : 1'b0;
        done = done_q;
    end

    // R5: never more than one select low.
    p_one_select_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~cs_n) <= 1);
    // R4: selects rest high while idle.
    p_idle_deselect_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (&cs_n));
    // R2: idle clock follows the polarity input.
    p_idle_clock_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && $past(!busy)) |-> (sclk == $past(cpol)));
    // R10: completion is a single-cycle pulse.
    p_done_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R10: completion only as a frame ends.
    p_done_end_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)));
endmodule

// File: tb/spi_ctl_bench.sv
// Bench: a serial device model checks every frame against a vector table,
// followed by directed tests for reset, idle level and ignored starts.
module spi_ctl_bench;
    typedef struct packed {
        logic        cpol;
        logic        cpha;
        logic        chain;
        logic [1:0]  sel;
        logic [5:0]  nbits;
        logic [2:0]  chl;
        logic [7:0]  div;
        logic [31:0] tx;
        logic [31:0] pat;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 1'b0, 1'b0, 2'd0, 6'd8,  3'd0, 8'd1, 32'h000000A5, 32'h0000003C},
        '{1'b0, 1'b1, 1'b0, 2'd1, 6'd16, 3'd0, 8'd0, 32'h00001234, 32'h0000BEEF},
        '{1'b1, 1'b0, 1'b0, 2'd2, 6'd5,  3'd0, 8'd2, 32'h00000013, 32'h0000000A},
        '{1'b1, 1'b1, 1'b0, 2'd3, 6'd32, 3'd0, 8'd0, 32'hDEADBEEF, 32'h8001F00D},
        '{1'b0, 1'b0, 1'b1, 2'd1, 6'd7,  3'd3, 8'd1, 32'h00C0FFEE, 32'h00A1B2C3},
        '{1'b0, 1'b1, 1'b0, 2'd0, 6'd1,  3'd0, 8'd3, 32'h00000001, 32'h00000001},
        '{1'b1, 1'b1, 1'b1, 2'd2, 6'd3,  3'd4, 8'd0, 32'hF00DCAFE, 32'h12345678}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        cpol = 1'b0;
    logic        cpha = 1'b0;
    logic        chain_en = 1'b0;
    logic [1:0]  sel = '0;
    logic [5:0]  nbits = 6'd8;
    logic [2:0]  chain_len = 3'd1;
    logic [7:0]  div = 8'd0;
    logic [31:0] tx_data = '0;
    logic        miso;
    logic        sclk;
    logic        mosi;
    logic [3:0]  cs_n;
    logic [31:0] rx_data;
    logic        busy;
    logic        done;

    logic [31:0] pat = '0;
    int nchk = 0;
    int nerr = 0;

    always #2 clk = ~clk;

    spi_ctl u_spi_ctl (
        .clk(clk), .rst_n(rst_n), .start(start), .cpol(cpol), .cpha(cpha),
        .chain_en(chain_en), .sel(sel), .nbits(nbits), .chain_len(chain_len),
        .div(div), .tx_data(tx_data), .miso(miso), .sclk(sclk), .mosi(mosi),
        .cs_n(cs_n), .rx_data(rx_data), .busy(busy), .done(done)
    );

    // Serial device model and timing monitor, evaluated away from the edge.
    int edges, leads, trails, gap, first_gap, lag, gap_bad, viol, multi, cs_idx;
    logic [31:0] cap;
    logic prev_sclk, prev_mosi;
    logic [3:0] prev_cs;
    int bidx;

    always_comb begin
        bidx = cpha ? ((leads > 0) ? leads - 1 : 0) : trails;
        if (bidx > 31) bidx = 31;
        miso = pat[bidx];
    end

    initial begin
        edges = 0; leads = 0; trails = 0; gap = 0; first_gap = 0; lag = 0;
        gap_bad = 0; viol = 0; multi = 0; cs_idx = -1; cap = '0;
        prev_sclk = 1'b0; prev_mosi = 1'b0; prev_cs = 4'hF;
    end

    always @(negedge clk) begin
        if (rst_n) begin
            if ($countones(~cs_n) > 1) multi = multi + 1;
            if (prev_cs == 4'hF && cs_n != 4'hF) begin
                edges = 0; leads = 0; trails = 0; gap = 0; first_gap = -1;
                gap_bad = 0; viol = 0; cap = '0; cs_idx = -1;
                for (int i = 0; i < 4; i++) if (!cs_n[i]) cs_idx = i;
            end else if (cs_n != 4'hF) begin
                gap = gap + 1;
                if (sclk != prev_sclk) begin
                    if (edges == 0) first_gap = gap;
                    else if (gap != int'(div) + 1) gap_bad = gap_bad + 1;
                    gap = 0;
                    if (((edges % 2) == 0) ^ cpha) begin
                        cap = {cap[30:0], mosi};
                        if (mosi != prev_mosi) viol = viol + 1;
                    end else if (cpha) begin
                        leads = leads + 1;
                    end else begin
                        trails = trails + 1;
                    end
                    if (cpha && (edges % 2) == 0 && leads == 0) leads = 1;
                    edges = edges + 1;
                end
            end else if (prev_cs != 4'hF) begin
                lag = gap + 1;
            end
        end
        prev_sclk = sclk;
        prev_mosi = mosi;
        prev_cs   = cs_n;
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        nchk = nchk + 1;
        if (!ok) begin
            nerr = nerr + 1;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Wait for the completion pulse; an overrun counts as a failed check.
    task automatic wait_done(output bit seen);
        seen = 1'b0;
        for (int c = 0; c < 5000 && !seen; c++) begin
            @(negedge clk);
            if (done) seen = 1'b1;
        end
        if (!seen) chk(1'b0, "R10 watchdog", 32'd0, 32'd1);
    endtask

    // Run one frame from a vector and compare against computed results.
    task automatic run_vec(input vec_t v, input bit extra_start);
        int len;
        logic [31:0] mask;
        bit seen;
        len  = v.chain ? 8 * int'(v.chl) : int'(v.nbits);
        mask = (len >= 32) ? 32'hFFFFFFFF : ((32'd1 << len) - 32'd1);
        @(negedge clk);
        cpol = v.cpol; cpha = v.cpha; chain_en = v.chain; sel = v.sel;
        nbits = v.nbits; chain_len = v.chl; div = v.div; tx_data = v.tx; pat = v.pat;
        repeat (3) @(negedge clk);
        chk(sclk == v.cpol, "R2 idle sclk", 32'(sclk), 32'(v.cpol));
        chk(mosi == 1'b0, "R6 idle mosi", 32'(mosi), 32'd0);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R10 busy after start", 32'(busy), 32'd1);
        if (extra_start) begin
            repeat (4) @(negedge clk);
            sel = v.sel + 2'd1; nbits = 6'd2; chain_en = 1'b0; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        wait_done(seen);
        chk(busy == 1'b0, "R10 busy low with done", 32'(busy), 32'd0);
        chk(edges == 2 * len, v.chain ? "R9 chained edge count" : "R8 edge count",
            32'(edges), 32'(2 * len));
        chk(cs_idx == int'(v.sel), "R5 selected line", 32'(cs_idx), 32'(v.sel));
        chk(multi == 0, "R5 single select", 32'(multi), 32'd0);
        chk(first_gap >= int'(v.div) + 1, "R4 select lead", 32'(first_gap), 32'(v.div + 1));
        chk(gap_bad == 0, "R1 half period", 32'(gap_bad), 32'd0);
        chk(viol == 0, "R3 mosi stable at sample edge", 32'(viol), 32'd0);
        chk(cap == (v.tx & mask), "R6 mosi order", cap, v.tx & mask);
        chk(rx_data == (v.pat & mask), "R7 rx order", rx_data, v.pat & mask);
        @(negedge clk);
        chk(done == 1'b0, "R10 done width", 32'(done), 32'd0);
        chk(lag >= int'(v.div) + 1, "R4 select lag", 32'(lag), 32'(v.div + 1));
        chk(cs_n == 4'hF, "R4 idle selects", 32'(cs_n), 32'hF);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        chk(cs_n == 4'hF, "R4 reset selects", 32'(cs_n), 32'hF);
        chk(busy == 1'b0 && done == 1'b0, "R10 reset flags", 32'({busy, done}), 32'd0);
        chk(sclk == 1'b0 && mosi == 1'b0, "R2 reset lines", 32'({sclk, mosi}), 32'd0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) run_vec(VECS[i], 1'b0);

        // R10: a second start during a frame changes neither length nor target.
        run_vec(VECS[0], 1'b1);
        // R9: chained mode ignores nbits (length still 8 per device).
        run_vec('{1'b1, 1'b0, 1'b1, 2'd3, 6'd32, 3'd1, 8'd0, 32'h0000005A, 32'h000000C3}, 1'b0);

        // R2: idle level follows a polarity change without any frame.
        @(negedge clk);
        cpol = 1'b1;
        repeat (2) @(negedge clk);
        chk(sclk == 1'b1 && cs_n == 4'hF, "R2 idle follows cpol", 32'(sclk), 32'd1);
        cpol = 1'b0;
        repeat (2) @(negedge clk);
        chk(sclk == 1'b0, "R2 idle follows cpol low", 32'(sclk), 32'd0);

        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    // Global watchdog: counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        nerr = nerr + 1;
        nchk = nchk + 1;
        $display("FAIL R10 global watchdog actual=0 expected=1");
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule